// File: doc/BRIEF.md
# Dual-Channel Comparator Edge and Wake-up Flag Controller

This block is the digital front end that sits behind two analog comparators. Each channel receives a comparator decision that has already been sampled. The block brings that decision into the bus clock domain and watches it for a rising edge, a falling edge or either edge, as chosen per channel. A matching edge sets a sticky interrupt flag. When wake-up is armed, the same edge also sets a sticky wake-up flag. Both kinds of flag drive request outputs, gated by the channel's interrupt enable.

A window-compare result is also formed from the two channels. It is high when channel 0 reads high and channel 1 reads low, which means the shared positive input lies between the two thresholds.

Software reaches the block through a small word-addressed register port. There is one control word per channel and one shared status word. Status flags are cleared by writing 1 to them. Reads are combinational on the current address.

Top module: `cmp_edge_irq`

## Requirements
- R1: After synchronous reset both control words, the status word, `irq_o` and `wake_o` are all 0.
- R2: The control word for channel 0 is at address 0 and the one for channel 1 is at address 1. Its bits are: enable at bit 0, interrupt enable at bit 1, edge polarity at bits 3:2, wake-up enable at bit 4, and window-mode select at bit 5 (this last bit is used only in channel 0's word). The status word is at address 2. In it, each enabled channel shows its synchronized input at bit 4+n (output) and at bit 12+n (status), two clock edges after the input changes.
- R3: While a channel's enable is 0, its bits 4+n and 12+n read 0, and no edge sets its flags.
- R4: Polarity 00 sets interrupt flag bit n (status bit 0 or 1) on either edge.
- R5: Polarity 01 sets the flag on a rising edge only.
- R6: Polarity 10 sets the flag on a falling edge only. Polarity 11 is reserved and sets the flag on no edge.
- R7: Writing the status word with 1 in a flag bit clears that flag. Writing 0 in a flag bit leaves that flag unchanged.
- R8: When an edge sets a flag in the same cycle that a write-1 tries to clear it, the flag ends up set.
- R9: `irq_o` is high while any channel whose interrupt enable is set holds its interrupt flag or its wake-up flag.
- R10: A matching edge sets wake-up flag bit 8+n only while wake-up enable is 1. `wake_o` is high while any channel with interrupt enable set holds its wake-up flag.
- R11: Status bit 16 is 1 one cycle after channel 0 reads 1 and channel 1 reads 0 while window mode is selected. Otherwise it is 0.
- R12: Enabling a channel whose input changed while it was disabled sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 2 | Sampled comparator decisions, bit n for channel n |
| reg_addr | input | ADDR_W | Word address of the register port |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Power-down wake-up request |

## Verification
The assertions take for granted that `cmp_in` may change at any time, because it passes through the synchronizer first. They also assume each register write lasts one cycle, so a clear pulse always matches one write. The stimulus changes inputs only on falling clock edges. It holds each comparator level for several cycles, so every level crosses both synchronizer stages before it is checked. The set-versus-clear collision is aimed at the exact cycle in which the synchronized edge is visible.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

    localparam int NCH = 2;

    typedef enum logic [1:0] {
        POL_BOTH = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_NONE = 2'b11
    } pol_e;

    // Control word layout, MSB first: bit5 window, bit4 wake, bits3:2 polarity, bit1 ie, bit0 en
    typedef struct packed {
        logic win_sel;
        logic wake_en;
        pol_e pol;
        logic irq_en;
        logic en;
    } ctl_t;

    localparam int CTL_W     = $bits(ctl_t);
    localparam int ST_IRQ    = 0;
    localparam int ST_OUT    = 4;
    localparam int ST_WAKE   = 8;
    localparam int ST_LIVE   = 12;
    localparam int ST_WIN    = 16;
    localparam int ADR_STAT  = 2;

    function automatic logic edge_match(pol_e pol, logic prev, logic cur);
        logic rise;
        logic fall;
        rise = !prev && cur;
        fall = prev && !cur;
        case (pol)
            POL_BOTH: return rise || fall;
            POL_RISE: return rise;
            POL_FALL: return fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= '0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
    import cmp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic s_in,
    input  logic clr_irq,
    input  logic clr_wake,
    output logic irq_flag,
    output logic wake_flag,
    output logic live
);
    logic prev_q;
    logic hit;

    // prev tracks the input even while disabled, so enabling sees no stale step
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= s_in;
    end

    assign hit  = ctl.en && edge_match(ctl.pol, prev_q, s_in);
    assign live = ctl.en && s_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag  <= 1'b0;
            wake_flag <= 1'b0;
        end else begin
            if (hit)          irq_flag <= 1'b1;
            else if (clr_irq) irq_flag <= 1'b0;
            if (hit && ctl.wake_en) wake_flag <= 1'b1;
            else if (clr_wake)      wake_flag <= 1'b0;
        end
    end

    a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag) |-> $past(clr_irq));
    a_r3_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en && !irq_flag) |=> !irq_flag);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq_flag);
    a_r10_wake_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (!ctl.wake_en && !wake_flag) |=> !wake_flag);
    a_r6_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        (ctl.pol == POL_NONE && !irq_flag) |=> !irq_flag);
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NCH-1:0]    irq_flag,
    input  logic [NCH-1:0]    wake_flag,
    input  logic [NCH-1:0]    live,
    input  logic              win,
    output ctl_t [NCH-1:0]    ctl,
    output logic [NCH-1:0]    clr_irq,
    output logic [NCH-1:0]    clr_wake,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(ADR_STAT);
    logic stat_wr;
    logic [DATA_W-1:0] status;

    assign stat_wr = reg_we && (reg_addr == STAT_A);

    for (genvar n = 0; n < NCH; n++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst)
                ctl[n] <= '0;
            else if (reg_we && reg_addr == ADDR_W'(n))
                ctl[n] <= ctl_t'(reg_wdata[CTL_W-1:0]);
        end
        assign clr_irq[n]  = stat_wr && reg_wdata[ST_IRQ+n];
        assign clr_wake[n] = stat_wr && reg_wdata[ST_WAKE+n];
    end

    always_comb begin
        status = '0;
        status[ST_IRQ  +: NCH] = irq_flag;
        status[ST_OUT  +: NCH] = live;
        status[ST_WAKE +: NCH] = wake_flag;
        status[ST_LIVE +: NCH] = live;
        status[ST_WIN]         = win;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STAT_A)
            reg_rdata = status;
        else
            for (int n = 0; n < NCH; n++)
                if (reg_addr == ADDR_W'(n)) reg_rdata[CTL_W-1:0] = ctl[n];
    end
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq
    import cmp_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmp_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              wake_o
);
    logic [NCH-1:0] s_q, irq_flag, wake_flag, live, clr_irq, clr_wake, ie;
    ctl_t [NCH-1:0] ctl;
    logic win_q;

    cmp_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .d(cmp_in), .q(s_q)
    );

    cmp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .irq_flag(irq_flag), .wake_flag(wake_flag),
        .live(live), .win(win_q), .ctl(ctl), .clr_irq(clr_irq),
        .clr_wake(clr_wake), .reg_rdata(reg_rdata)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        cmp_chan i_chan (
            .clk(clk), .rst(rst), .ctl(ctl[n]), .s_in(s_q[n]),
            .clr_irq(clr_irq[n]), .clr_wake(clr_wake[n]),
            .irq_flag(irq_flag[n]), .wake_flag(wake_flag[n]), .live(live[n])
        );
        assign ie[n] = ctl[n].irq_en;
    end

    // window: channel 0 above its threshold, channel 1 below its own
    always_ff @(posedge clk) begin
        if (rst) win_q <= 1'b0;
        else     win_q <= ctl[0].win_sel && live[0] && !live[1];
    end

    assign irq_o  = |(ie & (irq_flag | wake_flag));
    assign wake_o = |(ie & wake_flag);

    a_r11_window_off: assert property (@(posedge clk) disable iff (rst)
        !ctl[0].win_sel |=> !win_q);
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> |ie);
    a_r10_wake_implies_irq: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> irq_o);
endmodule

// File: tb/test_cmp_edge_irq.sv
`timescale 1ns/1ps
module test_cmp_edge_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmp_in = 2'b00;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, wake_o;
    int checks = 0;
    int errors = 0;
    logic [31:0] st;

    always #2 clk = ~clk;

    cmp_edge_irq i_cmp_edge_irq (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    // {polarity[1:0], start level, end level, expected flag}
    localparam logic [4:0] VEC [8] = '{
        5'b00_01_1, 5'b00_10_1, 5'b01_01_1, 5'b01_10_0,
        5'b10_01_0, 5'b10_10_1, 5'b11_01_0, 5'b11_10_0
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(0, st); chk("R1 ctl0", st, 0);
        rd(1, st); chk("R1 ctl1", st, 0);
        rd(2, st); chk("R1 status", st, 0);
        chk("R1 irq_o", irq_o, 0);
        chk("R1 wake_o", wake_o, 0);

        // polarity table on channel 0, interrupt enable off
        for (int i = 0; i < 8; i++) begin
            logic [4:0] v;
            string tag;
            v = VEC[i];
            case (v[4:3])
                2'b00: tag = "R4";
                2'b01: tag = "R5";
                default: tag = "R6";
            endcase
            wr(0, {28'd0, v[4:3], 2'b01});
            @(negedge clk) cmp_in[0] = v[2];
            settle(4);
            wr(2, 32'h303);
            @(negedge clk) cmp_in[0] = v[1];
            settle(5);
            rd(2, st);
            chk(tag, st[0], v[0]);
            chk("R9 gated", irq_o, 0);
        end
        wr(0, 0);
        @(negedge clk) cmp_in = 2'b00;
        settle(4);
        wr(2, 32'h303);

        // R2 live output and status bits
        wr(0, 1); wr(1, 1);
        @(negedge clk) cmp_in = 2'b01;
        settle(4); rd(2, st);
        chk("R2 out 01", st[5:4], 2'b01);
        chk("R2 sts 01", st[13:12], 2'b01);
        @(negedge clk) cmp_in = 2'b10;
        settle(4); rd(2, st);
        chk("R2 out 10", st[5:4], 2'b10);
        chk("R2 sts 10", st[13:12], 2'b10);

        // R3 disabled channel reads zero and sets nothing
        wr(1, 0);
        settle(1); rd(2, st);
        chk("R3 out1", st[5], 0);
        chk("R3 sts1", st[13], 0);
        wr(2, 32'h303);
        @(negedge clk) cmp_in[1] = 1'b0;
        settle(4);
        @(negedge clk) cmp_in[1] = 1'b1;
        settle(4); rd(2, st);
        chk("R3 no flag", st[1], 0);

        // R12 enabling after a change while disabled
        @(negedge clk) cmp_in[1] = 1'b0;
        settle(4);
        wr(1, 1);
        settle(4); rd(2, st);
        chk("R12 no flag", st[1], 0);

        // R7 write-1 clear, write-0 keep
        wr(2, 32'h303);
        @(negedge clk) cmp_in[0] = ~cmp_in[0];
        settle(4); rd(2, st);
        chk("R7 set", st[0], 1);
        wr(2, 32'hFFFF_FCFC);
        rd(2, st); chk("R7 write0 keeps", st[0], 1);
        wr(2, 32'h1);
        rd(2, st); chk("R7 write1 clears", st[0], 0);

        // R8 set and clear in the same cycle
        @(negedge clk) cmp_in[0] = ~cmp_in[0];
        @(posedge clk);
        @(posedge clk);
        wr(2, 32'h1);
        rd(2, st); chk("R8 set wins", st[0], 1);

        // R9 interrupt request gating
        wr(0, 32'h03);
        settle(1); chk("R9 irq on", irq_o, 1);
        wr(2, 32'h1);
        settle(1); chk("R9 irq off", irq_o, 0);

        // R10 wake-up flag and request
        @(negedge clk) cmp_in[0] = ~cmp_in[0];
        settle(4); rd(2, st);
        chk("R10 no wake flag", st[8], 0);
        chk("R10 no wake req", wake_o, 0);
        wr(2, 32'h303);
        wr(0, 32'h13);
        @(negedge clk) cmp_in[0] = ~cmp_in[0];
        settle(4); rd(2, st);
        chk("R10 wake flag", st[8], 1);
        chk("R10 wake req", wake_o, 1);
        wr(0, 32'h11);
        settle(1); rd(2, st);
        chk("R10 req gated", wake_o, 0);
        chk("R10 flag held", st[8], 1);
        wr(2, 32'h100);
        rd(2, st); chk("R10 wake clear", st[8], 0);
        wr(2, 32'h303);

        // R11 window compare
        wr(0, 32'h21); wr(1, 1);
        @(negedge clk) cmp_in = 2'b01;
        settle(4); rd(2, st); chk("R11 inside", st[16], 1);
        @(negedge clk) cmp_in = 2'b11;
        settle(4); rd(2, st); chk("R11 outside", st[16], 0);
        @(negedge clk) cmp_in = 2'b01;
        wr(0, 1);
        settle(4); rd(2, st); chk("R11 mode off", st[16], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule